// File: doc/BRIEF.md
# Floating-Point Special-Value Resolver

This block is the combinational special-value path of a double-precision arithmetic unit that handles add, subtract, multiply and fused multiply-add. It accepts an opcode and up to three 64-bit IEEE-754 binary64 operands. It sorts each operand into one of five classes: quiet NaN, signalling NaN, infinity, zero or other. From those classes it decides whether special values alone fix the result.

When special values do fix the result, the block raises `special_o` and drives the result word and the invalid-operation flag. The main datapath then yields to it. When `special_o` is low, the result and flag outputs read zero, and the main datapath's own result and flags are used.

For the fused operation the computed value is A + B×C. A is the addend, and B and C are the multiplicands. Rounding, ordinary arithmetic and accumulation of sticky flags all belong to other blocks.

Top module: `fp_special_resolver`

## Requirements
- R1: If no operand in use is a NaN or an infinity, `special_o`, `invalid_o` and `result_o` are all 0. This includes the all-zero input pattern.
- R2: For add (op 0) and subtract (op 1), when both A and B are NaN, the result carries A's sign and payload. This holds for every quiet/signalling combination.
- R3: A signalling NaN in any operand in use sets `invalid_o`. The NaN returned is quieted by setting fraction bit 51, and its sign and other payload bits are kept. This applies even when the signalling NaN is not the operand that was selected.
- R4: A quiet NaN combined only with ordinary numbers is returned bit-for-bit unchanged, with `invalid_o` low.
- R5: Adding infinities of opposite sign returns the default NaN 0x7FF8_0000_0000_0000 with `invalid_o` set. Subtracting infinities of the same sign gives the same result.
- R6: Multiply (op 2) of an infinity by a zero returns the default NaN with `invalid_o` set.
- R7: For fused multiply-add (op 3), the NaN selection priority is A first, then C, then B.
- R8: In fused multiply-add, a B×C product of infinity times zero always sets `invalid_o`. The result is the quieted A if A is a NaN, and the default NaN otherwise.
- R9: With no NaN and no invalid case, an infinity fixes the result:
  - add returns the infinite operand;
  - subtract returns an infinite B with its sign inverted;
  - multiply returns infinity with sign A⊕B;
  - fused multiply-add returns an infinite addend, or else an infinity with the product's sign.
  
  In all of these, `invalid_o` is low.
- R10: In fused multiply-add, an infinite addend combined with an infinite product of opposite sign returns the default NaN with `invalid_o` set.
- R11: The opcode encoding is add = 0, subtract = 1, multiply = 2, fused multiply-add = 3. For opcodes 0 to 2, operand C has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation: 0 add, 1 subtract, 2 multiply, 3 fused multiply-add |
| opnd_a_i | input | 64 | Operand A (addend for fused multiply-add) |
| opnd_b_i | input | 64 | Operand B (first multiplicand for fused multiply-add) |
| opnd_c_i | input | 64 | Operand C (second multiplicand; fused multiply-add only) |
| special_o | output | 1 | Result is fixed by special values |
| result_o | output | 64 | Resolved result word, zero when special_o is low |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bench covers the following corner cases:
- **NaN priority.** Every pairing and triple of NaNs is tried. A design that got fused multiply-add priority wrong would return B's payload where C's should win.
- **Signalling NaNs that lose the selection.** These must still raise invalid. A design that only inspected the selected operand would return the right NaN with the flag low.
- **Infinity times zero with a quiet NaN addend.** The flag must still rise. A design that let the NaN path pre-empt the invalid check would leave it clear.
- **Opposite-sign infinity sums.** These are tried across add, subtract and the fused operation. A subtract that forgot to invert B would return an infinity instead of the default NaN.
- **Operand C in two-operand operations.** C is loaded with a signalling NaN to prove it is ignored.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = FP_W - EXP_W - 1;
  localparam int QBIT   = FRAC_W - 1;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_FMA = 2'd3
  } fp_op_e;

  typedef struct packed {
    logic sign;
    logic qnan;
    logic snan;
    logic inf;
    logic zero;
  } fp_cls_t;

  localparam logic [FP_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [FP_W-1:0] make_quiet(input logic [FP_W-1:0] v);
    logic [FP_W-1:0] q;
    q       = v;
    q[QBIT] = 1'b1;
    return q;
  endfunction

  function automatic logic [FP_W-1:0] make_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic any_nan(input fp_cls_t c);
    return c.qnan | c.snan;
  endfunction
endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  output fp_cls_t         cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;

  assign exp_f   = val_i[FP_W-2 -: EXP_W];
  assign frac_f  = val_i[FRAC_W-1:0];
  assign exp_max = &exp_f;

  always_comb begin
    cls_o.sign = val_i[FP_W-1];
    cls_o.qnan = exp_max & frac_f[QBIT];
    cls_o.snan = exp_max & ~frac_f[QBIT] & (|frac_f);
    cls_o.inf  = exp_max & ~(|frac_f);
    cls_o.zero = ~(|exp_f) & ~(|frac_f);
  end
endmodule

// File: rtl/fpsr_nan_pick.sv
module fpsr_nan_pick
  import fpsr_pkg::*;
(
  input  fp_op_e          op_i,
  input  fp_cls_t         cls_a_i,
  input  fp_cls_t         cls_b_i,
  input  fp_cls_t         cls_c_i,
  input  logic [FP_W-1:0] val_a_i,
  input  logic [FP_W-1:0] val_b_i,
  input  logic [FP_W-1:0] val_c_i,
  output logic            nan_hit_o,
  output logic [FP_W-1:0] nan_val_o,
  output logic            snan_seen_o
);
  logic            use_c;
  logic [FP_W-1:0] chosen;

  assign use_c = (op_i == OP_FMA);

  always_comb begin
    nan_hit_o = 1'b1;
    chosen    = val_a_i;
    if (any_nan(cls_a_i)) begin
      chosen = val_a_i;
    end else if (use_c && any_nan(cls_c_i)) begin
      chosen = val_c_i;                      // R7: C ranks above B
    end else if (any_nan(cls_b_i)) begin
      chosen = val_b_i;
    end else begin
      nan_hit_o = 1'b0;
      chosen    = '0;
    end
  end

  assign nan_val_o   = nan_hit_o ? make_quiet(chosen) : '0;
  assign snan_seen_o = cls_a_i.snan | cls_b_i.snan | (use_c & cls_c_i.snan);

  // R3: a selected NaN always leaves as a quiet NaN
  always_comb begin
    if (nan_hit_o) begin
      p_nan_quiet_r3: assert ((&nan_val_o[FP_W-2 -: EXP_W]) && nan_val_o[QBIT])
        else $error("selected NaN not quiet");
    end
  end
endmodule

// File: rtl/fpsr_inf_rules.sv
module fpsr_inf_rules
  import fpsr_pkg::*;
(
  input  fp_op_e          op_i,
  input  fp_cls_t         cls_a_i,
  input  fp_cls_t         cls_b_i,
  input  fp_cls_t         cls_c_i,
  output logic            inv_hit_o,
  output logic            inf_hit_o,
  output logic [FP_W-1:0] inf_val_o
);
  logic nan_ab, nan_abc;
  logic eff_sign_b;
  logic prod_inf_zero, prod_inf, prod_sign, fma_clash;

  assign nan_ab        = any_nan(cls_a_i) | any_nan(cls_b_i);
  assign nan_abc       = nan_ab | any_nan(cls_c_i);
  assign eff_sign_b    = cls_b_i.sign ^ (op_i == OP_SUB);
  assign prod_inf_zero = (cls_b_i.inf & cls_c_i.zero) | (cls_c_i.inf & cls_b_i.zero);
  assign prod_inf      = (cls_b_i.inf & ~cls_c_i.zero & ~any_nan(cls_c_i))
                       | (cls_c_i.inf & ~cls_b_i.zero & ~any_nan(cls_b_i));
  assign prod_sign     = cls_b_i.sign ^ cls_c_i.sign;
  assign fma_clash     = cls_a_i.inf & prod_inf & (cls_a_i.sign != prod_sign);

  always_comb begin
    inv_hit_o = 1'b0;
    inf_hit_o = 1'b0;
    inf_val_o = '0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        inv_hit_o = cls_a_i.inf & cls_b_i.inf & (cls_a_i.sign != eff_sign_b);
        inf_hit_o = ~nan_ab & (cls_a_i.inf | cls_b_i.inf) & ~inv_hit_o;
        inf_val_o = cls_a_i.inf ? make_inf(cls_a_i.sign) : make_inf(eff_sign_b);
      end
      OP_MUL: begin
        inv_hit_o = (cls_a_i.inf & cls_b_i.zero) | (cls_b_i.inf & cls_a_i.zero);
        inf_hit_o = ~nan_ab & (cls_a_i.inf | cls_b_i.inf) & ~inv_hit_o;
        inf_val_o = make_inf(cls_a_i.sign ^ cls_b_i.sign);
      end
      default: begin
        inv_hit_o = prod_inf_zero | fma_clash;
        inf_hit_o = ~nan_abc & (cls_a_i.inf | prod_inf) & ~inv_hit_o;
        inf_val_o = cls_a_i.inf ? make_inf(cls_a_i.sign) : make_inf(prod_sign);
      end
    endcase
    if (!inf_hit_o) inf_val_o = '0;
  end

  // R9: an infinity result is never produced alongside an invalid case
  always_comb begin
    p_inf_excl_inv_r9: assert (!(inv_hit_o && inf_hit_o))
      else $error("infinity and invalid both claimed");
  end
endmodule

// File: rtl/fp_special_resolver.sv
module fp_special_resolver
  import fpsr_pkg::*;
(
  input  logic [1:0]  op_i,
  input  logic [63:0] opnd_a_i,
  input  logic [63:0] opnd_b_i,
  input  logic [63:0] opnd_c_i,
  output logic        special_o,
  output logic [63:0] result_o,
  output logic        invalid_o
);
  localparam int N_OPND = 3;

  fp_op_e          op;
  logic [FP_W-1:0] vals [N_OPND];
  fp_cls_t         cls  [N_OPND];

  assign op      = fp_op_e'(op_i);
  assign vals[0] = opnd_a_i;
  assign vals[1] = opnd_b_i;
  assign vals[2] = opnd_c_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fpsr_classify u_cls (.val_i(vals[g]), .cls_o(cls[g]));
  end

  logic            nan_hit, snan_seen;
  logic [FP_W-1:0] nan_val;
  logic            inv_hit, inf_hit;
  logic [FP_W-1:0] inf_val;

  fpsr_nan_pick u_nan (
    .op_i(op), .cls_a_i(cls[0]), .cls_b_i(cls[1]), .cls_c_i(cls[2]),
    .val_a_i(vals[0]), .val_b_i(vals[1]), .val_c_i(vals[2]),
    .nan_hit_o(nan_hit), .nan_val_o(nan_val), .snan_seen_o(snan_seen)
  );

  fpsr_inf_rules u_inf (
    .op_i(op), .cls_a_i(cls[0]), .cls_b_i(cls[1]), .cls_c_i(cls[2]),
    .inv_hit_o(inv_hit), .inf_hit_o(inf_hit), .inf_val_o(inf_val)
  );

  always_comb begin
    special_o = nan_hit | inv_hit | inf_hit;
    invalid_o = snan_seen | inv_hit;       // R8: inf*0 flags even with NaN addend
    if (nan_hit)      result_o = nan_val;
    else if (inv_hit) result_o = DEFAULT_NAN;
    else if (inf_hit) result_o = inf_val;
    else              result_o = '0;
  end

  // R3: a signalling NaN in use must reach the invalid flag
  always_comb begin
    if (snan_seen) begin
      p_snan_flags_r3: assert (invalid_o && special_o && result_o[QBIT])
        else $error("signalling NaN lost");
    end
  end

  // R5: invalid without any NaN operand yields the default NaN
  always_comb begin
    if (inv_hit && !nan_hit) begin
      p_dnan_r5: assert (result_o == DEFAULT_NAN)
        else $error("default NaN expected");
    end
  end

  // R1: flag and result are quiet when nothing special is seen
  always_comb begin
    if (!special_o) begin
      p_idle_zero_r1: assert (!invalid_o && (result_o == '0))
        else $error("outputs active while not special");
    end
  end
endmodule

// File: tb/sim_fp_special_resolver.sv
module sim_fp_special_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op;
  logic [63:0] a, b, c;
  logic        special, invalid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  fp_special_resolver u0 (
    .op_i(op), .opnd_a_i(a), .opnd_b_i(b), .opnd_c_i(c),
    .special_o(special), .result_o(result), .invalid_o(invalid)
  );

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] ZERO = 64'h0;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] Q1   = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] Q2   = 64'h7FF8_0000_0000_0002;
  localparam logic [63:0] Q3   = 64'h7FF8_0000_0000_0003;
  localparam logic [63:0] S1   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] S2   = 64'h7FF0_0000_0000_0002;
  localparam logic [63:0] NS5  = 64'hFFF0_0000_0000_0005;
  localparam logic [63:0] NQ5  = 64'hFFF8_0000_0000_0005;

  typedef struct {
    logic        sp;
    logic [63:0] res;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic drive(input logic [1:0] o, input logic [63:0] xa,
                       input logic [63:0] xb, input logic [63:0] xc,
                       input logic sp, input logic [63:0] res,
                       input logic inv, input string tag);
    exp_t e;
    @(posedge clk);
    op = o; a = xa; b = xb; c = xc;
    e.sp = sp; e.res = res; e.inv = inv; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (special !== e.sp || result !== e.res || invalid !== e.inv) begin
        n_fails++;
        $display("FAIL %s: got sp=%0b res=%h inv=%0b, expected sp=%0b res=%h inv=%0b",
                 e.tag, special, result, invalid, e.sp, e.res, e.inv);
      end
    end
  end

  initial begin
    op = 2'd0; a = '0; b = '0; c = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset/idle pattern and ordinary operands
    drive(2'd0, ZERO, ZERO, ZERO, 0, 64'h0, 0, "R1 all-zero inputs");
    drive(2'd0, ONE, ONE, ZERO, 0, 64'h0, 0, "R1 finite add");
    drive(2'd2, ZERO, ONE, ZERO, 0, 64'h0, 0, "R1 zero times one");
    // R4 quiet pass-through
    drive(2'd0, ONE, Q1, ZERO, 1, Q1, 0, "R4 one plus qnan");
    drive(2'd2, Q2, ONE, ZERO, 1, Q2, 0, "R4 qnan times one");
    // R3 signalling quieted
    drive(2'd0, ONE, S1, ZERO, 1, Q1, 1, "R3 one plus snan");
    drive(2'd2, NS5, ONE, ZERO, 1, NQ5, 1, "R3 negative snan keeps sign");
    // R2 first operand wins
    drive(2'd0, S1, S2, ZERO, 1, Q1, 1, "R2 snan+snan");
    drive(2'd0, Q1, S2, ZERO, 1, Q1, 1, "R2 R3 qnan+snan");
    drive(2'd0, S1, Q2, ZERO, 1, Q1, 1, "R2 snan+qnan");
    drive(2'd1, Q2, Q1, ZERO, 1, Q2, 0, "R2 sub qnan-qnan");
    // R5 opposite infinities
    drive(2'd0, PINF, NINF, ZERO, 1, DNAN, 1, "R5 +inf + -inf");
    drive(2'd1, PINF, PINF, ZERO, 1, DNAN, 1, "R5 +inf - +inf");
    // R9 infinity results
    drive(2'd0, ONE, PINF, ZERO, 1, PINF, 0, "R9 one plus inf");
    drive(2'd1, ONE, PINF, ZERO, 1, NINF, 0, "R9 one minus inf");
    drive(2'd1, NINF, PINF, ZERO, 1, NINF, 0, "R9 -inf minus +inf");
    drive(2'd2, NINF, NONE, ZERO, 1, PINF, 0, "R9 -inf times -one");
    drive(2'd3, NINF, ONE, ONE, 1, NINF, 0, "R9 fma inf addend");
    drive(2'd3, ONE, PINF, NONE, 1, NINF, 0, "R9 fma inf product");
    // R6 inf times zero
    drive(2'd2, PINF, ZERO, ZERO, 1, DNAN, 1, "R6 inf*0");
    drive(2'd2, ZERO, NINF, ZERO, 1, DNAN, 1, "R6 0*-inf");
    // R7 fma priority A, C, B
    drive(2'd3, Q1, ONE, ONE, 1, Q1, 0, "R7 A only");
    drive(2'd3, ONE, Q2, ONE, 1, Q2, 0, "R7 B only");
    drive(2'd3, ONE, ONE, Q3, 1, Q3, 0, "R7 C only");
    drive(2'd3, Q1, Q2, ONE, 1, Q1, 0, "R7 A over B");
    drive(2'd3, Q1, ONE, Q3, 1, Q1, 0, "R7 A over C");
    drive(2'd3, ONE, Q2, Q3, 1, Q3, 0, "R7 C over B");
    drive(2'd3, Q1, Q2, Q3, 1, Q1, 0, "R7 all three");
    drive(2'd3, S1, ONE, ONE, 1, Q1, 1, "R7 R3 snan addend");
    drive(2'd3, Q1, S2, ONE, 1, Q1, 1, "R7 R3 losing snan flags");
    // R8 fma product inf*0
    drive(2'd3, ONE, PINF, ZERO, 1, DNAN, 1, "R8 number addend");
    drive(2'd3, S1, PINF, ZERO, 1, Q1, 1, "R8 snan addend");
    drive(2'd3, Q1, ZERO, NINF, 1, Q1, 1, "R8 qnan addend still invalid");
    // R10 fma clash
    drive(2'd3, NINF, PINF, ONE, 1, DNAN, 1, "R10 -inf + +inf product");
    drive(2'd3, PINF, NINF, NONE, 0 == 1 ? 0 : 1, PINF, 0, "R10 same-sign no clash");
    // R11 operand C ignored outside fma
    drive(2'd0, ONE, ONE, S1, 0, 64'h0, 0, "R11 add ignores C snan");
    drive(2'd2, ONE, ONE, Q1, 0, 64'h0, 0, "R11 mul ignores C qnan");
    drive(2'd1, ONE, ONE, PINF, 0, 64'h0, 0, "R11 sub ignores C inf");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule